// File: doc/BRIEF.md
# Prioritised Interrupt Status Unit

This block collects single-cycle event pulses from the command path, the data path and a DMA engine of a storage host controller. Each pulse is held in a raw status bit until software clears it. Software clears a bit by writing a one to it. A per-bit enable mask turns raw status into masked status. A global enable gates the OR of all masked bits onto one interrupt line.

Error conditions are ranked in a fixed order, which spans the main status register and a smaller DMA status register. The most urgent pending masked error is reported as a small code. Interrupt service software can therefore pick the error to handle from a single read instead of testing bit after bit. All state sits behind a word-addressed register port. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `isu_top`

## Requirements
- R1: After reset, every register reads as zero, `irq` is 0 and `errCode` is 0.
- R2: An event pulse sets its raw status bit on the next clock edge. Main bits: 0 command done, 1 data transfer complete, 2 auto-stop complete, 3 data starvation timeout, 4 FIFO underrun/overflow, 5 command busy/illegal write, 6 response timeout, 7 response CRC error, 8 response error, 9 data timeout, 10 data CRC error, 11 data start-bit error, 12 data end-bit error. DMA bits: 0 transmit done, 1 receive done, 2 descriptor unavailable, 3 fatal bus error.
- R3: A write to a raw status address (main 2, DMA 5) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Masked status (main at address 3, DMA at address 6) reads as raw status AND the mask (main mask at address 1, DMA mask at address 4).
- R6: Writing all ones to address 2 clears every main bit. Writing 0x3FF to address 5 clears every DMA bit. Neither write touches the other register.
- R7: `irq` equals control bit 0 (address 0, global enable) AND the OR of all masked main and DMA bits.
- R8: `errCode` (also readable at address 7) is 0 when no masked error bit is set. Otherwise it takes the value of the highest-priority masked main error: main bits 3 through 12 give codes 1 through 10, and the lower bit index wins.
- R9: Masked DMA bits 2 and 3 both give code 11. This code appears only when no masked main error bit is set. Done bits (main 0 to 2, DMA 0 to 1) never produce a code.
- R10: Control and mask registers read back the value last written to them, truncated to their width. Writes to the read-only addresses 3, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for both read and write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr`, zero-extended |
| mainEvt | input | 13 | Event pulses for the main status bits |
| dmaEvt | input | 4 | Event pulses for the DMA status bits |
| irq | output | 1 | Interrupt line |
| errCode | output | 4 | Code of the highest-priority pending masked error |

## Verification
The two functions that can land on the same clock edge are event capture and the write-one-to-clear path. They can also meet on the same status bit. The bench provokes this by holding an event pulse high in the same cycle as the clearing write. It also sets other bits that the same write clears. The result is read back after the edge: the bit that had the event must stay set, and the bits without an event must be cleared. All other checks sweep every status bit and every pair of error bits, and compare against a priority code that the bench computes itself.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int MAIN_W   = 13;
  localparam int DMA_W    = 4;
  localparam int CODE_W   = 4;
  localparam int SEL_W    = 3;

  // Main status bit positions (behavioural: priority follows index)
  localparam int MB_CMD_DONE  = 0;
  localparam int MB_XFER_DONE = 1;
  localparam int MB_STOP_DONE = 2;
  localparam int MB_FIRST_ERR = 3;
  localparam int MB_LAST_ERR  = 12;

  // DMA status bit positions
  localparam int DB_TX_DONE   = 0;
  localparam int DB_RX_DONE   = 1;
  localparam int DB_NO_DESC   = 2;
  localparam int DB_BUS_FAULT = 3;

  localparam logic [CODE_W-1:0] CODE_NONE = '0;
  localparam logic [CODE_W-1:0] CODE_DMA  = CODE_W'(MB_LAST_ERR - MB_FIRST_ERR + 2);

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_MMASK = 3'd1,
    SEL_MRAW  = 3'd2,
    SEL_MMSK  = 3'd3,
    SEL_DMASK = 3'd4,
    SEL_DRAW  = 3'd5,
    SEL_DMSK  = 3'd6,
    SEL_CODE  = 3'd7
  } regSel_t;

  typedef struct packed {
    logic    gieWe;
    logic    mainMaskWe;
    logic    mainClrWe;
    logic    dmaMaskWe;
    logic    dmaClrWe;
    logic    rdHit;
    regSel_t rdSel;
  } isuStrobe_t;
endpackage

// File: rtl/isu_ctrl.sv
module isu_ctrl
  import isu_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output isuStrobe_t        stb
);
  logic    hit;
  regSel_t sel;
  logic    wrHit;

  generate
    if (ADDR_W > SEL_W) begin : g_wide
      assign hit = (addr[ADDR_W-1:SEL_W] == '0);
    end else begin : g_exact
      assign hit = 1'b1;
    end
  endgenerate

  assign sel   = regSel_t'(addr[SEL_W-1:0]);
  assign wrHit = wrEn & hit;

  always_comb begin
    stb            = '0;
    stb.rdHit      = hit;
    stb.rdSel      = sel;
    stb.gieWe      = wrHit && (sel == SEL_CTRL);
    stb.mainMaskWe = wrHit && (sel == SEL_MMASK);
    stb.mainClrWe  = wrHit && (sel == SEL_MRAW);
    stb.dmaMaskWe  = wrHit && (sel == SEL_DMASK);
    stb.dmaClrWe   = wrHit && (sel == SEL_DRAW);
  end
endmodule

// File: rtl/isu_prio.sv
module isu_prio
  import isu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MAIN_W-1:0] mainMsk,
  input  logic [DMA_W-1:0]  dmaMsk,
  output logic [CODE_W-1:0] errCode
);
  logic dmaErr;
  assign dmaErr = dmaMsk[DB_NO_DESC] | dmaMsk[DB_BUS_FAULT];

  always_comb begin
    errCode = CODE_NONE;
    if (dmaErr) errCode = CODE_DMA;
    // walk from lowest to highest priority so the most urgent wins
    for (int i = MB_LAST_ERR; i >= MB_FIRST_ERR; i--) begin
      if (mainMsk[i]) errCode = CODE_W'(i - MB_FIRST_ERR + 1);
    end
  end

  a_r8_top_rank: assert property (@(posedge clk) disable iff (!rstN)
    mainMsk[MB_FIRST_ERR] |-> errCode == CODE_W'(1));
  a_r8_code_range: assert property (@(posedge clk) disable iff (!rstN)
    errCode <= CODE_DMA);
  a_r9_dma_below: assert property (@(posedge clk) disable iff (!rstN)
    (|mainMsk[MB_LAST_ERR:MB_FIRST_ERR]) |-> (errCode != CODE_DMA && errCode != CODE_NONE));
endmodule

// File: rtl/isu_datapath.sv
module isu_datapath
  import isu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  isuStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [MAIN_W-1:0] mainEvt,
  input  logic [DMA_W-1:0]  dmaEvt,
  input  logic [CODE_W-1:0] errCode,
  output logic [MAIN_W-1:0] mainMsk,
  output logic [DMA_W-1:0]  dmaMsk,
  output logic              gie,
  output logic              irq,
  output logic [DATA_W-1:0] rdData
);
  logic [MAIN_W-1:0] mainRaw, mainMask, mainClr;
  logic [DMA_W-1:0]  dmaRaw, dmaMask, dmaClr;
  logic              unusedHi;

  assign unusedHi = ^wrData[DATA_W-1:MAIN_W];
  assign mainClr  = stb.mainClrWe ? wrData[MAIN_W-1:0] : '0;
  assign dmaClr   = stb.dmaClrWe  ? wrData[DMA_W-1:0]  : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gie      <= 1'b0;
      mainMask <= '0;
      dmaMask  <= '0;
    end else begin
      if (stb.gieWe)      gie      <= wrData[0];
      if (stb.mainMaskWe) mainMask <= wrData[MAIN_W-1:0];
      if (stb.dmaMaskWe)  dmaMask  <= wrData[DMA_W-1:0];
    end
  end

  generate
    for (genvar i = 0; i < MAIN_W; i++) begin : g_main
      always_ff @(posedge clk) begin
        if (!rstN) mainRaw[i] <= 1'b0;
        else       mainRaw[i] <= (mainRaw[i] & ~mainClr[i]) | mainEvt[i];
      end
      a_r3_main_clear: assert property (@(posedge clk) disable iff (!rstN)
        (mainClr[i] && !mainEvt[i]) |=> !mainRaw[i]);
      a_r3_main_hold: assert property (@(posedge clk) disable iff (!rstN)
        (!mainClr[i] && !mainEvt[i]) |=> mainRaw[i] == $past(mainRaw[i]));
      a_r4_main_evt_wins: assert property (@(posedge clk) disable iff (!rstN)
        mainEvt[i] |=> mainRaw[i]);
    end
    for (genvar j = 0; j < DMA_W; j++) begin : g_dma
      always_ff @(posedge clk) begin
        if (!rstN) dmaRaw[j] <= 1'b0;
        else       dmaRaw[j] <= (dmaRaw[j] & ~dmaClr[j]) | dmaEvt[j];
      end
      a_r3_dma_clear: assert property (@(posedge clk) disable iff (!rstN)
        (dmaClr[j] && !dmaEvt[j]) |=> !dmaRaw[j]);
      a_r4_dma_evt_wins: assert property (@(posedge clk) disable iff (!rstN)
        dmaEvt[j] |=> dmaRaw[j]);
    end
  endgenerate

  assign mainMsk = mainRaw & mainMask;
  assign dmaMsk  = dmaRaw & dmaMask;
  assign irq     = gie & ((|mainMsk) | (|dmaMsk));

  always_comb begin
    rdData = '0;
    if (stb.rdHit) begin
      unique case (stb.rdSel)
        SEL_CTRL:  rdData = DATA_W'(gie);
        SEL_MMASK: rdData = DATA_W'(mainMask);
        SEL_MRAW:  rdData = DATA_W'(mainRaw);
        SEL_MMSK:  rdData = DATA_W'(mainMsk);
        SEL_DMASK: rdData = DATA_W'(dmaMask);
        SEL_DRAW:  rdData = DATA_W'(dmaRaw);
        SEL_DMSK:  rdData = DATA_W'(dmaMsk);
        SEL_CODE:  rdData = DATA_W'(errCode);
        default:   rdData = '0;
      endcase
    end
  end

  a_r6_dma_clear_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dmaClrWe && dmaEvt == '0) |=> mainRaw == (($past(mainRaw)) | $past(mainEvt)));
endmodule

// File: rtl/isu_top.sv
module isu_top
  import isu_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [12:0]       mainEvt,
  input  logic [3:0]        dmaEvt,
  output logic              irq,
  output logic [3:0]        errCode
);
  isuStrobe_t        stb;
  logic [MAIN_W-1:0] mainMsk;
  logic [DMA_W-1:0]  dmaMsk;
  logic              gie;

  isu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  isu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .mainEvt (mainEvt),
    .dmaEvt  (dmaEvt),
    .errCode (errCode),
    .mainMsk (mainMsk),
    .dmaMsk  (dmaMsk),
    .gie     (gie),
    .irq     (irq),
    .rdData  (rdData)
  );

  isu_prio u_prio (
    .clk     (clk),
    .rstN    (rstN),
    .mainMsk (mainMsk),
    .dmaMsk  (dmaMsk),
    .errCode (errCode)
  );

  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !gie |-> !irq);
  a_r7_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (errCode != CODE_NONE || mainMsk[MB_STOP_DONE:MB_CMD_DONE] != '0
             || dmaMsk[DB_RX_DONE:DB_TX_DONE] != '0));
endmodule

// File: tb/tb_isu_top.sv
module tb_isu_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [12:0] mainEvt = '0;
  logic [3:0]  dmaEvt = '0;
  logic        irq;
  logic [3:0]  errCode;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  isu_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .mainEvt(mainEvt), .dmaEvt(dmaEvt), .irq(irq), .errCode(errCode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic evt(input logic [12:0] m, input logic [3:0] d);
    @(negedge clk); mainEvt = m; dmaEvt = d;
    @(negedge clk); mainEvt = '0; dmaEvt = '0;
  endtask

  task automatic evtWr(input logic [12:0] m, input logic [3:0] d,
                       input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); mainEvt = m; dmaEvt = d; wrEn = 1'b1; addr = a; wrData = v;
    @(negedge clk); mainEvt = '0; dmaEvt = '0; wrEn = 1'b0; wrData = '0;
  endtask

  function automatic logic [3:0] expCode(input logic [12:0] m, input logic [3:0] d);
    for (int i = 3; i <= 12; i++) if (m[i]) return 4'(i - 2);
    if (d[2] | d[3]) return 4'd11;
    return 4'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R1 reset reg", v, 0);
    end
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset code", 32'(errCode), 0);

    // Sweep main bits: R2 R3 R5 R7 R8 R10
    for (int i = 0; i < 13; i++) begin
      evt(13'(1 << i), 4'd0);
      rd(3'd2, v); chk("R2 main raw", v, 32'(1 << i));
      rd(3'd3, v); chk("R5 main masked off", v, 0);
      chk("R8 code unmasked", 32'(errCode), 0);
      wr(3'd1, 32'h1FFF);
      rd(3'd1, v); chk("R10 main mask readback", v, 32'h1FFF);
      rd(3'd3, v); chk("R5 main masked on", v, 32'(1 << i));
      chk("R8 main code", 32'(errCode), 32'(expCode(13'(1 << i), 4'd0)));
      rd(3'd7, v); chk("R8 code register", v, 32'(expCode(13'(1 << i), 4'd0)));
      chk("R7 irq gie off", 32'(irq), 0);
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); chk("R10 ctrl readback", v, 1);
      chk("R7 irq gie on", 32'(irq), 1);
      wr(3'd2, 32'(~(1 << i) & 32'h1FFF));
      rd(3'd2, v); chk("R3 zero write keeps", v, 32'(1 << i));
      wr(3'd2, 32'(1 << i));
      rd(3'd2, v); chk("R3 one write clears", v, 0);
      chk("R7 irq drops", 32'(irq), 0);
      wr(3'd0, 0); wr(3'd1, 0);
    end

    // Sweep DMA bits: R2 R3 R5 R7 R9
    for (int j = 0; j < 4; j++) begin
      evt(13'd0, 4'(1 << j));
      rd(3'd5, v); chk("R2 dma raw", v, 32'(1 << j));
      rd(3'd6, v); chk("R5 dma masked off", v, 0);
      wr(3'd4, 32'hF);
      rd(3'd4, v); chk("R10 dma mask readback", v, 32'hF);
      rd(3'd6, v); chk("R5 dma masked on", v, 32'(1 << j));
      chk("R9 dma code", 32'(errCode), 32'(expCode(13'd0, 4'(1 << j))));
      wr(3'd0, 1);
      chk("R7 irq dma", 32'(irq), 1);
      wr(3'd5, 32'(1 << j));
      rd(3'd5, v); chk("R3 dma clear", v, 0);
      chk("R7 irq dma drops", 32'(irq), 0);
      wr(3'd0, 0); wr(3'd4, 0);
    end

    // R8 R9 pairwise priority with a DMA error pending
    wr(3'd1, 32'h1FFF); wr(3'd4, 32'hF);
    for (int i = 3; i <= 12; i++) begin
      for (int k = i + 1; k <= 12; k++) begin
        evt(13'((1 << i) | (1 << k)), 4'b1000);
        chk("R8 pair priority", 32'(errCode), 32'(i - 2));
        wr(3'd2, 32'h1FFF);
        chk("R9 dma after main cleared", 32'(errCode), 11);
        wr(3'd5, 32'h3FF);
      end
    end
    evt(13'h0007, 4'b0011);
    chk("R9 done bits no code", 32'(errCode), 0);
    wr(3'd2, 32'h1FFF); wr(3'd5, 32'h3FF);

    // R8 partial mask: only the lower-priority error is enabled
    evt(13'h1008, 4'd0);
    wr(3'd1, 32'h1000);
    chk("R8 masked-off high bit skipped", 32'(errCode), 10);
    wr(3'd2, 32'h1FFF);

    // R10 writes to read-only addresses ignored
    evt(13'h0010, 4'd0);
    wr(3'd1, 32'h1FFF);
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R10 read-only write ignored", v, 32'h0010);
    rd(3'd1, v); chk("R10 mask unchanged", v, 32'h1FFF);
    chk("R10 code unchanged", 32'(errCode), 2);
    wr(3'd2, 32'h1FFF);

    // R6 clear-all
    evt(13'h1FFF, 4'hF);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R6 main cleared", v, 0);
    rd(3'd5, v); chk("R6 dma untouched", v, 32'hF);
    wr(3'd5, 32'h3FF);
    rd(3'd5, v); chk("R6 dma cleared", v, 0);

    // R4 event and clear in the same cycle
    evt(13'h00A0, 4'd0);
    evtWr(13'h0020, 4'd0, 3'd2, 32'h1FFF);
    rd(3'd2, v); chk("R4 main event wins", v, 32'h0020);
    evt(13'd0, 4'hF);
    evtWr(13'd0, 4'h2, 3'd5, 32'h3FF);
    rd(3'd5, v); chk("R4 dma event wins", v, 32'h2);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule